// File: doc/BRIEF.md
# Previous Instruction Address Capture Register

This block holds a 64-bit control register with the address of the last instruction that completed while interruption collection was enabled. Each cycle the retire stage presents at most one completed or faulting instruction. The block decides whether that instruction counts and, if it does, loads its address. In native mode the address is the 16-byte bundle address. In legacy mode it is the zero-extended byte address. When an interruption arrives and clears collection, updates stop and the value stays where it is. Handler software can then find the instruction that trapped, or the last good one before a fault.

Software may read and write the register only while collection is off. An access while collection is on raises an illegal-operation fault. A `defined` flag records whether the contents are meaningful. An interruption or a legal software write makes it meaningful. An explicit change of the collection bit by an instruction makes it undefined.

Top module: `prev_addr_capture`

## Requirements
- R1: A retired native-mode instruction (`ret_legacy`=0) with `ret_fault`=0 and `ic_before`=1 loads its address with bits 3:0 forced to zero at the next clock edge.
- R2: A retired legacy-mode instruction (`ret_legacy`=1) with `ic_before`=1 loads `ret_addr[LEG_AW-1:0]` zero-extended to 64 bits, with bits 3:0 kept, whether it faulted or not.
- R3: A native-mode instruction retiring with `ret_fault`=1 leaves the register unchanged.
- R4: A retire with `ic_before`=0 never changes the register, including the case `ic_after`=1 (return from interruption turning collection on).
- R5: While `coll_en`=1, `sw_rd` or `sw_wr` raises `illegal_op` in the same cycle, drives `rd_data` to zero, and a write does not change the register.
- R6: While `coll_en`=0, `sw_wr` loads all 64 bits of `sw_wdata` at the next edge and takes priority over a simultaneous retire capture. `sw_rd` returns the register on `rd_data` in the same cycle.
- R7: An instruction that completes and then raises a trap (for example a taken branch) is recorded like any other completed instruction, and the value is held after the interruption that follows.
- R8: `defined` becomes 1 after an edge with `intr`=1 and `coll_en`=1, or after a legal software write. Otherwise it becomes 0 after a retire whose `ic_before` differs from `ic_after`.
- R9: After reset the register is zero, `defined`=0, and with no access active `illegal_op`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid | input | 1 | An instruction retires or faults this cycle |
| ret_addr | input | 64 | Address of that instruction |
| ret_legacy | input | 1 | 1 = legacy byte-granular mode, 0 = native bundle mode |
| ret_fault | input | 1 | The instruction faulted instead of completing |
| ic_before | input | 1 | Collection-enable value before the instruction |
| ic_after | input | 1 | Collection-enable value after the instruction |
| intr | input | 1 | An interruption is taken this cycle |
| coll_en | input | 1 | Current collection-enable status bit |
| sw_rd | input | 1 | Software read request |
| sw_wr | input | 1 | Software write request |
| sw_wdata | input | 64 | Software write data |
| addr_q | output | 64 | Register contents |
| rd_data | output | 64 | Read data, zero unless a legal read is active |
| illegal_op | output | 1 | Access attempted while collection is enabled |
| defined | output | 1 | Register contents are meaningful |

## Verification
A wrong capture decision shows on `addr_q` one edge after the retire that caused it. The wrong cases include a missing low-bit clear, a bad zero-extension, an update while collection was off, or a native fault that overwrote the value. A fault in the access gate shows in the same cycle as a spurious or missing `illegal_op`, or as nonzero read data. A write that slipped through shows on `addr_q` one edge later. A wrong `defined` state shows one edge after the interruption, the write or the explicit bit change.

// File: rtl/pac_pkg.sv
// Package: shared types for the previous-address capture register.
// Assumes nothing beyond SystemVerilog 2017.
package pac_pkg;
    // What a retire event asks the register to do.
    typedef enum logic [1:0] {
        CAP_NONE   = 2'd0,
        CAP_BUNDLE = 2'd1,
        CAP_BYTE   = 2'd2
    } cap_kind_e;
endpackage

// File: rtl/pac_capture_sel.sv
// Module: pac_capture_sel
// Classifies a retire event and forms the address to capture.
// Assumes: at most one retire per cycle; legacy addresses use LEG_AW low bits.
module pac_capture_sel
    import pac_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int LEG_AW    = 32,
    parameter int SLOT_BITS = 4
) (
    input  logic            ret_valid,
    input  logic            ret_legacy,
    input  logic            ret_fault,
    input  logic            ic_before,
    input  logic [XLEN-1:0] ret_addr,
    output cap_kind_e       kind,
    output logic [XLEN-1:0] cap_val
);
    localparam logic [XLEN-1:0] BUNDLE_MASK = {{(XLEN-SLOT_BITS){1'b1}}, {SLOT_BITS{1'b0}}};

    logic [XLEN-1:0] leg_ext;

    // Zero-extend the legacy byte address; the variant follows LEG_AW.
    generate
        if (LEG_AW < XLEN) begin : g_ext
            assign leg_ext = {{(XLEN-LEG_AW){1'b0}}, ret_addr[LEG_AW-1:0]};
        end else begin : g_full
            assign leg_ext = ret_addr;
        end
    endgenerate

    // Decide whether and how the event updates the register.
    always_comb begin
        kind = CAP_NONE;
        if (ret_valid && ic_before) begin
            if (ret_legacy)      kind = CAP_BYTE;
            else if (!ret_fault) kind = CAP_BUNDLE;
        end
    end

    // Select the address form that matches the capture kind.
    always_comb begin
        cap_val = (kind == CAP_BYTE) ? leg_ext : (ret_addr & BUNDLE_MASK);
    end
endmodule

// File: rtl/pac_sw_gate.sv
// Module: pac_sw_gate
// Gates software access on the collection-enable bit.
// Assumes: read data is combinational from the register.
module pac_sw_gate #(
    parameter int XLEN = 64
) (
    input  logic            coll_en,
    input  logic            sw_rd,
    input  logic            sw_wr,
    input  logic [XLEN-1:0] reg_q,
    output logic            wr_ok,
    output logic [XLEN-1:0] rd_data,
    output logic            illegal_op
);
    // Flag accesses while enabled; pass legal reads and writes.
    always_comb begin
        illegal_op = coll_en && (sw_rd || sw_wr);
        wr_ok      = !coll_en && sw_wr;
        rd_data    = (!coll_en && sw_rd) ? reg_q : '0;
    end
endmodule

// File: rtl/pac_defined_track.sv
// Module: pac_defined_track
// Tracks whether the register contents are meaningful.
// Assumes: an explicit change of collection-enable arrives as a retire whose
// before and after values differ.
module pac_defined_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ret_valid,
    input  logic ic_before,
    input  logic ic_after,
    input  logic intr,
    input  logic coll_en,
    input  logic wr_ok,
    output logic defined
);
    logic set_ev;
    logic clr_ev;

    // Events that make the contents meaningful or stale.
    always_comb begin
        set_ev = (intr && coll_en) || wr_ok;
        clr_ev = ret_valid && (ic_before != ic_after);
    end

    // Flag register; a set event wins over a clear event.
    always_ff @(posedge clk) begin
        if (!rst_n)      defined <= 1'b0;
        else if (set_ev) defined <= 1'b1;
        else if (clr_ev) defined <= 1'b0;
    end
endmodule

// File: rtl/prev_addr_capture.sv
// Module: prev_addr_capture (top)
// Holds the address of the last instruction that completed with collection
// enabled. Software may access it only while collection is off.
// Assumes: XLEN stays 64, since all bits are kept regardless of address width.
module prev_addr_capture
    import pac_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int LEG_AW    = 32,
    parameter int SLOT_BITS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ret_valid,
    input  logic [XLEN-1:0] ret_addr,
    input  logic            ret_legacy,
    input  logic            ret_fault,
    input  logic            ic_before,
    input  logic            ic_after,
    input  logic            intr,
    input  logic            coll_en,
    input  logic            sw_rd,
    input  logic            sw_wr,
    input  logic [XLEN-1:0] sw_wdata,
    output logic [XLEN-1:0] addr_q,
    output logic [XLEN-1:0] rd_data,
    output logic            illegal_op,
    output logic            defined
);
    cap_kind_e       kind;
    logic [XLEN-1:0] cap_val;
    logic            wr_ok;

    pac_capture_sel #(.XLEN(XLEN), .LEG_AW(LEG_AW), .SLOT_BITS(SLOT_BITS)) u_sel (
        .ret_valid  (ret_valid),
        .ret_legacy (ret_legacy),
        .ret_fault  (ret_fault),
        .ic_before  (ic_before),
        .ret_addr   (ret_addr),
        .kind       (kind),
        .cap_val    (cap_val)
    );

    pac_sw_gate #(.XLEN(XLEN)) u_gate (
        .coll_en    (coll_en),
        .sw_rd      (sw_rd),
        .sw_wr      (sw_wr),
        .reg_q      (addr_q),
        .wr_ok      (wr_ok),
        .rd_data    (rd_data),
        .illegal_op (illegal_op)
    );

    pac_defined_track u_def (
        .clk       (clk),
        .rst_n     (rst_n),
        .ret_valid (ret_valid),
        .ic_before (ic_before),
        .ic_after  (ic_after),
        .intr      (intr),
        .coll_en   (coll_en),
        .wr_ok     (wr_ok),
        .defined   (defined)
    );

    // Address register; a legal software write beats a hardware capture.
    always_ff @(posedge clk) begin
        if (!rst_n)                addr_q <= '0;
        else if (wr_ok)            addr_q <= sw_wdata;
        else if (kind != CAP_NONE) addr_q <= cap_val;
    end
endmodule

// File: rtl/prev_addr_capture_chk.sv
// Module: prev_addr_capture_chk
// Port-level temporal checks for prev_addr_capture, attached by bind.
// Assumes: the same parameters as the bound instance.
module prev_addr_capture_chk #(
    parameter int XLEN      = 64,
    parameter int LEG_AW    = 32,
    parameter int SLOT_BITS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ret_valid,
    input logic [XLEN-1:0] ret_addr,
    input logic            ret_legacy,
    input logic            ret_fault,
    input logic            ic_before,
    input logic            ic_after,
    input logic            intr,
    input logic            coll_en,
    input logic            sw_rd,
    input logic            sw_wr,
    input logic [XLEN-1:0] sw_wdata,
    input logic [XLEN-1:0] addr_q,
    input logic [XLEN-1:0] rd_data,
    input logic            illegal_op,
    input logic            defined
);
    localparam logic [XLEN-1:0] MASK = {{(XLEN-SLOT_BITS){1'b1}}, {SLOT_BITS{1'b0}}};

    logic            sw_legal_wr;
    logic [XLEN-1:0] leg_ext;
    assign sw_legal_wr = sw_wr && !coll_en;
    assign leg_ext     = XLEN'(ret_addr[LEG_AW-1:0]);

    // R1: a native completion loads the bundle-aligned address.
    a_r1_native_bundle: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid && ic_before && !ret_legacy && !ret_fault && !sw_legal_wr
        |=> addr_q == ($past(ret_addr) & MASK));

    // R2: a legacy event loads the zero-extended byte address.
    a_r2_legacy_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid && ic_before && ret_legacy && !sw_legal_wr
        |=> addr_q == $past(leg_ext));

    // R3: a native fault leaves the register alone.
    a_r3_native_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid && ic_before && !ret_legacy && ret_fault && !sw_legal_wr
        |=> $stable(addr_q));

    // R4: no update without collection enabled beforehand.
    a_r4_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ret_valid && ic_before) && !sw_legal_wr |=> $stable(addr_q));

    // R5: an access while enabled faults and returns no data.
    a_r5_illegal_access: assert property (@(posedge clk) disable iff (!rst_n)
        coll_en && (sw_rd || sw_wr) |-> illegal_op && rd_data == '0);

    // R5: a rejected write does not alter the register.
    a_r5_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        coll_en && sw_wr && !(ret_valid && ic_before) |=> $stable(addr_q));

    // R6: a legal write loads all bits.
    a_r6_write: assert property (@(posedge clk) disable iff (!rst_n)
        sw_legal_wr |=> addr_q == $past(sw_wdata));

    // R8: an interruption with collection on makes the contents meaningful.
    a_r8_defined_on_intr: assert property (@(posedge clk) disable iff (!rst_n)
        intr && coll_en |=> defined);

    // R8: an explicit collection-bit change makes the contents stale.
    a_r8_explicit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid && (ic_before != ic_after) && !intr && !sw_legal_wr |=> !defined);
endmodule

bind prev_addr_capture prev_addr_capture_chk #(
    .XLEN(XLEN), .LEG_AW(LEG_AW), .SLOT_BITS(SLOT_BITS)
) u_chk (.*);

// File: tb/tb_prev_addr_capture.sv
// Bench for prev_addr_capture: a table walk of retire events, then directed tests.
module tb_prev_addr_capture;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ret_valid, ret_legacy, ret_fault, ic_before, ic_after;
    logic [63:0] ret_addr, sw_wdata;
    logic        intr, coll_en, sw_rd, sw_wr;
    logic [63:0] addr_q, rd_data;
    logic        illegal_op, defined;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    prev_addr_capture dut (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_addr(ret_addr),
        .ret_legacy(ret_legacy), .ret_fault(ret_fault), .ic_before(ic_before),
        .ic_after(ic_after), .intr(intr), .coll_en(coll_en), .sw_rd(sw_rd),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata), .addr_q(addr_q), .rd_data(rd_data),
        .illegal_op(illegal_op), .defined(defined)
    );

    // Vector: [131] legacy, [130] fault, [129] ic_before, [128] ic_after,
    // [127:64] retire address, [63:0] expected register after the edge.
    localparam int NV = 8;
    localparam logic [131:0] VEC [NV] = '{
        {4'b0011, 64'h0000_1234_5678_9ABC, 64'h0000_1234_5678_9AB0}, // R1
        {4'b1011, 64'hFFFF_FFFF_8000_1237, 64'h0000_0000_8000_1237}, // R2
        {4'b0111, 64'h0000_0000_0000_2000, 64'h0000_0000_8000_1237}, // R3
        {4'b1111, 64'h0000_0000_0040_0005, 64'h0000_0000_0040_0005}, // R2/R3
        {4'b0001, 64'h0000_0000_0000_5550, 64'h0000_0000_0040_0005}, // R4
        {4'b0000, 64'h0000_0000_0000_7770, 64'h0000_0000_0040_0005}, // R4
        {4'b0011, 64'hFEDC_BA98_7654_321F, 64'hFEDC_BA98_7654_3210}, // R1
        {4'b1011, 64'h0000_0000_0000_000F, 64'h0000_0000_0000_000F}  // R2
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        ret_valid = 0; ret_legacy = 0; ret_fault = 0; ic_before = 0; ic_after = 0;
        ret_addr = '0; intr = 0; sw_rd = 0; sw_wr = 0; sw_wdata = '0;
    endtask

    // Let one clock edge pass, then return to the falling edge.
    task automatic edge_pass();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        coll_en = 1;
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R9: reset state.
        chk("R9 addr", addr_q, 64'h0);
        chk("R9 defined", {63'h0, defined}, 64'h0);
        chk("R9 illegal", {63'h0, illegal_op}, 64'h0);
        chk("R9 rd_data", rd_data, 64'h0);
        rst_n = 1;
        edge_pass();

        // R1 R2 R3 R4: table walk.
        for (int i = 0; i < NV; i++) begin
            ret_valid  = 1;
            ret_legacy = VEC[i][131];
            ret_fault  = VEC[i][130];
            ic_before  = VEC[i][129];
            ic_after   = VEC[i][128];
            ret_addr   = VEC[i][127:64];
            edge_pass();
            idle();
            chk($sformatf("R1-4 table vector %0d", i), addr_q, VEC[i][63:0]);
        end

        // R5: read while enabled faults and returns zero.
        sw_rd = 1;
        #1;
        chk("R5 read illegal", {63'h0, illegal_op}, 64'h1);
        chk("R5 read data", rd_data, 64'h0);
        idle();
        // R5: write while enabled faults and changes nothing.
        sw_wr = 1; sw_wdata = 64'hDEAD_BEEF_0000_1111;
        #1;
        chk("R5 write illegal", {63'h0, illegal_op}, 64'h1);
        edge_pass();
        idle();
        chk("R5 write ignored", addr_q, 64'h0000_0000_0000_000F);

        // R6: legal write and read with collection off; R8 defined set.
        coll_en = 0;
        sw_wr = 1; sw_wdata = 64'hA5A5_5A5A_C3C3_3C3F;
        edge_pass();
        idle();
        chk("R6 write", addr_q, 64'hA5A5_5A5A_C3C3_3C3F);
        chk("R8 defined by write", {63'h0, defined}, 64'h1);
        sw_rd = 1;
        #1;
        chk("R6 read data", rd_data, 64'hA5A5_5A5A_C3C3_3C3F);
        chk("R6 read legal", {63'h0, illegal_op}, 64'h0);
        idle();
        // R6: write wins over a simultaneous retire capture.
        sw_wr = 1; sw_wdata = 64'h1111_2222_3333_4444;
        ret_valid = 1; ic_before = 1; ic_after = 1; ret_addr = 64'h9990;
        edge_pass();
        idle();
        chk("R6 write priority", addr_q, 64'h1111_2222_3333_4444);

        // R8: an explicit clear of collection makes the contents stale.
        coll_en = 1;
        ret_valid = 1; ic_before = 1; ic_after = 0; ret_addr = 64'h0000_0000_0000_8880;
        edge_pass();
        idle();
        chk("R8 explicit clear", {63'h0, defined}, 64'h0);
        chk("R1 capture on clearing instr", addr_q, 64'h8880);

        // R7: a trapping branch completes, then the interruption freezes it.
        ret_valid = 1; ic_before = 1; ic_after = 1; ret_addr = 64'h0000_0000_0010_0047;
        edge_pass();
        idle();
        intr = 1;
        edge_pass();
        idle();
        coll_en = 0;
        chk("R7 branch bundle held", addr_q, 64'h0000_0000_0010_0040);
        chk("R8 defined by interruption", {63'h0, defined}, 64'h1);
        // R4: return from interruption turns collection on without updating.
        ret_valid = 1; ic_before = 0; ic_after = 1; ret_addr = 64'h0000_0000_0020_0000;
        edge_pass();
        idle();
        coll_en = 1;
        chk("R4 return no update", addr_q, 64'h0000_0000_0010_0040);
        chk("R8 explicit set stale", {63'h0, defined}, 64'h0);

        // R9: reset again clears everything.
        rst_n = 0;
        edge_pass();
        chk("R9 re-reset addr", addr_q, 64'h0);
        chk("R9 re-reset defined", {63'h0, defined}, 64'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule